// File: doc/BRIEF.md
# Table-Driven Branch Target Unit

This unit resolves the next instruction address for a branch whose destination sits in a table of halfword offsets in memory. It accepts a start request with its operands, computes the address of the table entry, reads that entry through a single request/valid memory port, and turns the returned halfword into a 32-bit target. It reports the target with a one-cycle done pulse.

It has two modes. In call mode a 6-bit index selects an entry relative to a base-pointer value. The entry is an unsigned offset from the aligned base. In switch mode a register value indexes a table that starts right after the 2-byte switch instruction. The entry is a signed halfword count relative to that same point.

The unit handles one request at a time. A start that arrives while a request is in progress is dropped, not queued.

Top module: `tbt_unit`

## Requirements
- R1: With `mode_i`=0 (call mode), the read address is (`base_i` with bit 0 cleared) + 2 × `index_i`, where `index_i` is zero-extended.
- R2: In call mode the target is (`base_i` with bit 0 cleared) + the 16-bit entry, with the entry zero-extended and its bit 0 cleared. The sum wraps modulo 2^32.
- R3: With `mode_i`=1 (switch mode), the read address is (`pc_i` + 2) + 2 × `reg_i`, modulo 2^32.
- R4: In switch mode the target is (`pc_i` + 2) + 2 × (the entry sign-extended from bit 15). Bit 0 of the entry is kept.
- R5: `mem_req_o` rises in the cycle after start is accepted. It stays high with `mem_addr_o` unchanged until the cycle in which `mem_valid_i` is high, and it is low in the cycle after that.
- R6: `done_o` is high for exactly one cycle, in the cycle after the one in which `mem_valid_i` is accepted. `target_o` is valid from that cycle and holds its value until the next completed request.
- R7: While `busy_o` is high, `start_i` has no effect: the address, the target and the sequence of the request in progress are unchanged, and no second read follows.
- R8: After reset `busy_o`, `mem_req_o` and `done_o` are low and `target_o` is zero.
- R9: `busy_o` is high from the cycle after an accepted start through the done cycle. `done_o` is never high together with `mem_req_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a lookup; sampled only when idle |
| mode_i | input | 1 | 0 selects call mode, 1 selects switch mode |
| base_i | input | 32 | Table base pointer (call mode) |
| index_i | input | 6 | Entry index (call mode) |
| pc_i | input | 32 | Address of the switch instruction (switch mode) |
| reg_i | input | 32 | Register index value (switch mode) |
| busy_o | output | 1 | A request is in progress |
| mem_req_o | output | 1 | Halfword read request |
| mem_addr_o | output | 32 | Byte address of the table entry |
| mem_valid_i | input | 1 | Read data valid; completes the request |
| mem_rdata_i | input | 16 | Halfword read data |
| done_o | output | 1 | One-cycle completion pulse |
| target_o | output | 32 | Computed next instruction address |

## Verification
The start is sampled at a clock edge, and the request and its address appear in the next cycle. For a memory that answers L cycles into the request (L = 0 to 3), `done_o` and the new target are due L+1 cycles after that first request cycle. That makes L+2 edges from the start edge. The bench samples every cycle at the falling edge after the start edge. It expects request and address in cycles 0 to L, and done and the target exactly in cycle L+1. In the cycle after that it checks that done has dropped and that the target is held. Ignored starts are driven inside these windows, and the bench then confirms that the address, the target and the request timing are unchanged.

// File: rtl/tbt_pkg.sv
package tbt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WAIT,
    ST_DONE
  } tbt_state_e;

  typedef enum logic {
    MODE_CALL   = 1'b0,
    MODE_SWITCH = 1'b1
  } tbt_mode_e;
endpackage

// File: rtl/tbt_addr_gen.sv
module tbt_addr_gen
  import tbt_pkg::*;
#(
  parameter int AW    = 32,
  parameter int IDX_W = 6,
  parameter int INSN_BYTES = 2
) (
  input  tbt_mode_e         mode_i,
  input  logic [AW-1:0]     base_i,
  input  logic [IDX_W-1:0]  index_i,
  input  logic [AW-1:0]     pc_i,
  input  logic [AW-1:0]     reg_i,
  output logic [AW-1:0]     anchor_o,
  output logic [AW-1:0]     offset_o
);
  localparam logic [AW-1:0] INSN_LEN = AW'(INSN_BYTES);

  logic [AW-1:0] idx_ext;
  assign idx_ext = {{(AW-IDX_W){1'b0}}, index_i};

  always_comb begin
    if (mode_i == MODE_CALL) begin
      anchor_o = {base_i[AW-1:1], 1'b0};
      offset_o = {idx_ext[AW-2:0], 1'b0};
    end else begin
      anchor_o = pc_i + INSN_LEN;
      offset_o = {reg_i[AW-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/tbt_target_calc.sv
module tbt_target_calc
  import tbt_pkg::*;
#(
  parameter int AW    = 32,
  parameter int ENT_W = 16
) (
  input  tbt_mode_e          mode_i,
  input  logic [AW-1:0]      anchor_i,
  input  logic [ENT_W-1:0]   entry_i,
  output logic [AW-1:0]      target_o
);
  localparam int PAD = AW - ENT_W;

  logic [AW-1:0] call_off;
  logic [AW-1:0] sw_off;

  // call: unsigned, forced even; switch: signed halfword count
  assign call_off = {{PAD{1'b0}}, entry_i[ENT_W-1:1], 1'b0};
  assign sw_off   = {{(PAD-1){entry_i[ENT_W-1]}}, entry_i, 1'b0};

  assign target_o = anchor_i + ((mode_i == MODE_CALL) ? call_off : sw_off);
endmodule

// File: rtl/tbt_ctrl.sv
module tbt_ctrl
  import tbt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic mem_valid_i,
  output logic accept_o,
  output logic capture_o,
  output logic busy_o,
  output logic req_o,
  output logic done_o
);
  tbt_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_ADDR;
      ST_ADDR: state_d = mem_valid_i ? ST_DONE : ST_WAIT;
      ST_WAIT: if (mem_valid_i) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign req_o     = (state_q == ST_ADDR) || (state_q == ST_WAIT);
  assign done_o    = (state_q == ST_DONE);
  assign busy_o    = (state_q != ST_IDLE);
  assign accept_o  = (state_q == ST_IDLE) && start_i;
  assign capture_o = req_o && mem_valid_i;

  a_r5_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !mem_valid_i) |=> req_o);
  a_r5_req_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && mem_valid_i) |=> !req_o);
  a_r6_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r9_done_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !req_o);
endmodule

// File: rtl/tbt_unit.sv
module tbt_unit
  import tbt_pkg::*;
#(
  parameter int AW    = 32,
  parameter int IDX_W = 6,
  parameter int ENT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             mode_i,
  input  logic [AW-1:0]    base_i,
  input  logic [IDX_W-1:0] index_i,
  input  logic [AW-1:0]    pc_i,
  input  logic [AW-1:0]    reg_i,
  output logic             busy_o,
  output logic             mem_req_o,
  output logic [AW-1:0]    mem_addr_o,
  input  logic             mem_valid_i,
  input  logic [ENT_W-1:0] mem_rdata_i,
  output logic             done_o,
  output logic [AW-1:0]    target_o
);
  tbt_mode_e     mode_in, mode_q;
  logic [AW-1:0] anchor_d, offset_d, anchor_q, offset_q;
  logic [AW-1:0] target_d, target_q;
  logic          accept, capture;

  assign mode_in = tbt_mode_e'(mode_i);

  tbt_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .mem_valid_i(mem_valid_i),
    .accept_o   (accept),
    .capture_o  (capture),
    .busy_o     (busy_o),
    .req_o      (mem_req_o),
    .done_o     (done_o)
  );

  tbt_addr_gen #(.AW(AW), .IDX_W(IDX_W)) u_addr (
    .mode_i  (mode_in),
    .base_i  (base_i),
    .index_i (index_i),
    .pc_i    (pc_i),
    .reg_i   (reg_i),
    .anchor_o(anchor_d),
    .offset_o(offset_d)
  );

  tbt_target_calc #(.AW(AW), .ENT_W(ENT_W)) u_tgt (
    .mode_i  (mode_q),
    .anchor_i(anchor_q),
    .entry_i (mem_rdata_i),
    .target_o(target_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_CALL;
      anchor_q <= '0;
      offset_q <= '0;
    end else if (accept) begin
      mode_q   <= mode_in;
      anchor_q <= anchor_d;
      offset_q <= offset_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      target_q <= '0;
    else if (capture) target_q <= target_d;
  end

  assign mem_addr_o = anchor_q + offset_q;
  assign target_o   = target_q;

  a_r5_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_valid_i) |=> $stable(mem_addr_o));
  a_r7_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(mem_addr_o));
  a_r6_done_after_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(mem_req_o && mem_valid_i));
  a_r6_target_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || !busy_o) |=> (!done_o && !busy_o) || $stable(target_o) || $past(done_o) == 1'b0);
  a_r9_busy_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (busy_o && mem_req_o));
endmodule

// File: tb/sim_tbt_unit.sv
module sim_tbt_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        mode = 1'b0;
  logic [31:0] base = '0;
  logic [5:0]  index = '0;
  logic [31:0] pc = '0;
  logic [31:0] regv = '0;
  logic        busy, req, done, valid;
  logic [31:0] addr, target;
  logic [15:0] entry = '0;
  logic [1:0]  lat = '0;
  logic [1:0]  wcnt;
  int          checks = 0;
  int          errors = 0;

  always #2.5 clk = ~clk;

  // memory model: answers lat cycles into the request
  assign valid = req && (wcnt == lat);
  always @(posedge clk) begin
    if (req && !valid) wcnt <= wcnt + 2'd1;
    else               wcnt <= '0;
  end
  initial wcnt = '0;

  tbt_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .base_i(base), .index_i(index), .pc_i(pc), .reg_i(regv),
    .busy_o(busy), .mem_req_o(req), .mem_addr_o(addr),
    .mem_valid_i(valid), .mem_rdata_i(entry),
    .done_o(done), .target_o(target)
  );

  typedef struct packed {
    logic        md;
    logic [31:0] a;
    logic [31:0] b;
    logic [15:0] ent;
    logic [1:0]  lt;
    logic [31:0] exp_addr;
    logic [31:0] exp_tgt;
  } vec_t;

  // md=0: a=base, b=index; md=1: a=pc, b=reg
  localparam vec_t VECS [7] = '{
    '{1'b0, 32'h0000_1001, 32'd5,         16'h0124, 2'd0, 32'h0000_100A, 32'h0000_1124},
    '{1'b0, 32'h0000_2000, 32'd63,        16'h8003, 2'd2, 32'h0000_207E, 32'h0000_A002},
    '{1'b1, 32'h0000_4000, 32'd3,         16'h0010, 2'd1, 32'h0000_4008, 32'h0000_4022},
    '{1'b1, 32'h0000_4000, 32'd0,         16'hFFFF, 2'd3, 32'h0000_4002, 32'h0000_4000},
    '{1'b1, 32'h8000_0000, 32'h10,        16'h8000, 2'd0, 32'h8000_0022, 32'h7FFF_0002},
    '{1'b1, 32'h0000_0100, 32'hFFFF_FFFF, 16'h0005, 2'd1, 32'h0000_0100, 32'h0000_010C},
    '{1'b0, 32'hFFFF_FFFF, 32'd0,         16'hFFFF, 2'd3, 32'hFFFF_FFFE, 32'h0000_FFFC}
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // intr: 1 = pulse start during request, 2 = hold start in done cycle
  task automatic run(input vec_t v, input string rq_a, input string rq_t, input int intr);
    @(negedge clk);
    mode = v.md; entry = v.ent; lat = v.lt;
    if (v.md == 1'b0) begin
      base = v.a; index = v.b[5:0]; pc = 32'hDEAD_BEE0; regv = 32'h1234;
    end else begin
      pc = v.a; regv = v.b; base = 32'h5555_5555; index = 6'h2A;
    end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int n = 0; n <= int'(v.lt) + 1; n++) begin
      if (n <= int'(v.lt)) begin
        chk("R5 req", {31'd0, req}, 32'd1);
        chk("R9 busy", {31'd0, busy}, 32'd1);
        chk(rq_a, addr, v.exp_addr);
        chk("R6 no early done", {31'd0, done}, 32'd0);
        if (intr == 1 && n == 0) begin
          start = 1'b1; mode = ~v.md; base = 32'h0F0F_0F00; pc = 32'h0F0F_0F00; index = 6'h11;
        end
      end else begin
        chk("R6 done", {31'd0, done}, 32'd1);
        chk("R9 no req at done", {31'd0, req}, 32'd0);
        chk(rq_t, target, v.exp_tgt);
        if (intr == 2) start = 1'b1;
      end
      @(negedge clk);
      if (intr == 1 && n == 0) start = 1'b0;
    end
    start = 1'b0;
    chk("R6 done one cycle", {31'd0, done}, 32'd0);
    chk("R6 target held", target, v.exp_tgt);
    chk("R5 req dropped", {31'd0, req}, 32'd0);
    if (intr == 2) begin
      chk("R7 done-cycle start ignored", {31'd0, busy}, 32'd0);
      @(negedge clk);
      chk("R7 no second read", {31'd0, req}, 32'd0);
      chk("R7 target unchanged", target, v.exp_tgt);
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk("R8 busy", {31'd0, busy}, 32'd0);
    chk("R8 req", {31'd0, req}, 32'd0);
    chk("R8 done", {31'd0, done}, 32'd0);
    chk("R8 target", target, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 idle after release", {31'd0, busy}, 32'd0);

    foreach (VECS[i]) begin
      if (VECS[i].md == 1'b0) run(VECS[i], "R1 call addr", "R2 call target", 0);
      else                    run(VECS[i], "R3 switch addr", "R4 switch target", 0);
    end

    // R7: starts while busy are dropped
    run(VECS[1], "R7 addr kept", "R7 target kept", 1);
    run(VECS[3], "R7 addr kept", "R7 target kept", 2);

    // R4: odd entry with latency 0, bit 0 kept
    run('{1'b1, 32'h0000_0FFE, 32'd1, 16'h7FFF, 2'd0, 32'h0000_1002, 32'h0001_0FFE},
        "R3 switch addr", "R4 switch odd entry", 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule